// File: doc/BRIEF.md
# Message Object Interrupt Prioritizer

This block gathers interrupt requests for a bus controller with 32 message objects and reduces them to one interrupt line. Each message object raises a one-cycle event pulse when it completes a transfer. The pulse latches a pending bit only when that object's own enable is set. The controller core also raises four event pulses: transfer completed, bus error detected, bus-off entered and error counter at its limit. The first two feed a status interrupt and the last two feed an error interrupt. Each of the two has its own enable bit in the control register.

Software reads a cause register to find what to service. The cause register holds a reserved status code when the status or error interrupt is pending. Otherwise it holds the number of the lowest-numbered pending object, or zero when nothing is pending. Reading the status register clears the status and error interrupts. A write to the clear register removes one object's pending bit, or clears the status interrupt when the status code is written. A global enable gates the interrupt line.

Access is through a simple register port. A write takes effect at the clock edge where `bus_wr` is high. Read data is registered and appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `msg_irq_prioritizer`

## Requirements
- R1: After reset, `irq_o` is 0 and the control, status, cause, both pending and both object-enable registers read 0.
- R2: An event pulse on `obj_evt[n-1]` sets the pending bit of object n only if object n's enable bit is set. Object n's enable is bit n-1 of the low enable register (offset 6) for n up to 16, and bit n-17 of the high enable register (offset 7) above that. Pending bits use the same layout in the low (offset 3) and high (offset 4) pending registers.
- R3: When only object bits are pending, the cause register (offset 2) reads the smallest pending object number, in the range 1 to 32.
- R4: The cause register reads 16'h8000 whenever the status or error interrupt is pending, even while object bits are pending. It reads 0 when nothing is pending.
- R5: A transfer-done or bus-error pulse sets the status interrupt only when control bit 1 is set.
- R6: A bus-off or error-limit pulse sets the error interrupt only when control bit 2 is set.
- R7: The status register (offset 1) holds sticky event flags. Bit 0 is transfer-done, bit 1 is bus-error, bit 2 is bus-off and bit 3 is error-limit, and these latch whatever the enables are. Bit 4 is the status interrupt and bit 5 is the error interrupt. A read returns the value before the clear and then clears all six bits.
- R8: Writing a value from 1 to 32 to the clear register (offset 5) clears that object's pending bit. Writing 16'h8000 clears the whole status register. Any other value has no effect.
- R9: `irq_o` is high exactly when control bit 0 (global enable) is set and at least one object, status or error interrupt is pending.
- R10: When an event and a clear of the same bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| obj_evt | input | 32 | Per-object event pulses, bit n-1 for object n |
| ev_xfer_done | input | 1 | Transfer completed pulse |
| ev_bus_err | input | 1 | Bus error detected pulse |
| ev_bus_off | input | 1 | Bus-off entered pulse |
| ev_err_limit | input | 1 | Error counter at limit pulse |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench targets the priority edges: object 1 and object 32 pending together, and status pending while objects are also pending. An encoder that scanned in the wrong direction, or gave objects precedence over status, would report the wrong cause. It writes the out-of-range clear values 0, 33 and 16'h4000 and checks that the pending mask does not change. A decoder that truncated or wrapped the value would wipe an unrelated bit. It fires an event and a clear of the same object in one cycle. A design that gave the clear priority would lose that interrupt. It also checks that a status read returns the flags as they were before the clear, and that events with their enables off latch flags but raise nothing.

// File: rtl/mip_pkg.sv
package mip_pkg;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam logic [DW-1:0] STAT_CODE = 16'h8000;

    localparam logic [AW-1:0] A_CTRL  = 3'd0;
    localparam logic [AW-1:0] A_STAT  = 3'd1;
    localparam logic [AW-1:0] A_CAUSE = 3'd2;
    localparam logic [AW-1:0] A_PLO   = 3'd3;
    localparam logic [AW-1:0] A_PHI   = 3'd4;
    localparam logic [AW-1:0] A_CLR   = 3'd5;
    localparam logic [AW-1:0] A_IELO  = 3'd6;
    localparam logic [AW-1:0] A_IEHI  = 3'd7;

    typedef struct packed {
        logic err_en;
        logic stat_en;
        logic glob_en;
    } ctrl_t;

    typedef struct packed {
        logic       err_pend;
        logic       stat_pend;
        logic [3:0] flags;
    } stat_t;
endpackage

// File: rtl/mip_obj_bank.sv
module mip_obj_bank #(
    parameter int NOBJ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NOBJ-1:0] obj_evt,
    input  logic [NOBJ-1:0] obj_ie,
    input  logic [NOBJ-1:0] clr_mask,
    output logic [NOBJ-1:0] pend
);
    logic [NOBJ-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q & ~clr_mask) | (obj_evt & obj_ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    // R2
    pend_rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q)) & ~$past(obj_evt & obj_ie)) == '0);

    // R8
    pend_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend_q & $past(pend_q)) & ~$past(clr_mask)) == '0);

    // R8
    clear_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_mask));
endmodule

// File: rtl/mip_evt_ctrl.sv
module mip_evt_ctrl
    import mip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stat_en,
    input  logic  err_en,
    input  logic  ev_xfer_done,
    input  logic  ev_bus_err,
    input  logic  ev_bus_off,
    input  logic  ev_err_limit,
    input  logic  clr_all,
    output stat_t stat
);
    stat_t st_d, st_q;

    always_comb begin
        st_d = clr_all ? '0 : st_q;
        if (ev_xfer_done) st_d.flags[0] = 1'b1;
        if (ev_bus_err)   st_d.flags[1] = 1'b1;
        if (ev_bus_off)   st_d.flags[2] = 1'b1;
        if (ev_err_limit) st_d.flags[3] = 1'b1;
        if (stat_en && (ev_xfer_done || ev_bus_err)) st_d.stat_pend = 1'b1;
        if (err_en && (ev_bus_off || ev_err_limit))  st_d.err_pend  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q;

    // R5
    stat_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stat_pend) |-> $past(stat_en && (ev_xfer_done || ev_bus_err)));

    // R6
    err_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err_pend) |-> $past(err_en && (ev_bus_off || ev_err_limit)));

    // R7
    stat_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.stat_pend) || $fell(st_q.err_pend)) |-> $past(clr_all));
endmodule

// File: rtl/mip_cause_enc.sv
module mip_cause_enc
    import mip_pkg::*;
#(
    parameter int NOBJ = 32
) (
    input  logic [NOBJ-1:0] pend,
    input  logic            stat_any,
    output logic [DW-1:0]   cause
);
    logic [DW-1:0] obj_num;

    always_comb begin
        obj_num = '0;
        for (int i = NOBJ - 1; i >= 0; i--) begin
            if (pend[i]) obj_num = DW'(i + 1);
        end
        cause = stat_any ? STAT_CODE : obj_num;
    end
endmodule

// File: rtl/msg_irq_prioritizer.sv
module msg_irq_prioritizer
    import mip_pkg::*;
#(
    parameter int NOBJ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NOBJ-1:0] obj_evt,
    input  logic            ev_xfer_done,
    input  logic            ev_bus_err,
    input  logic            ev_bus_off,
    input  logic            ev_err_limit,
    output logic            irq_o
);
    localparam int HALF = NOBJ / 2;
    localparam int IW   = $clog2(NOBJ);

    typedef struct packed {
        ctrl_t           ctrl;
        logic [NOBJ-1:0] ie;
        logic [DW-1:0]   rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NOBJ-1:0] pend;
    logic [NOBJ-1:0] clr_mask;
    logic            clr_all;
    stat_t           stat;
    logic [DW-1:0]   cause;
    logic            stat_any;

    assign stat_any = stat.stat_pend | stat.err_pend;

    always_comb begin
        for (int i = 0; i < NOBJ; i++) begin
            clr_mask[i] = bus_wr && (bus_addr == A_CLR) && (bus_wdata == DW'(i + 1));
        end
        clr_all = (bus_wr && (bus_addr == A_CLR) && (bus_wdata == STAT_CODE))
               || (bus_rd && (bus_addr == A_STAT));
    end

    mip_obj_bank #(.NOBJ(NOBJ)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .obj_evt  (obj_evt),
        .obj_ie   (r_q.ie),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    mip_evt_ctrl u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .stat_en      (r_q.ctrl.stat_en),
        .err_en       (r_q.ctrl.err_en),
        .ev_xfer_done (ev_xfer_done),
        .ev_bus_err   (ev_bus_err),
        .ev_bus_off   (ev_bus_off),
        .ev_err_limit (ev_err_limit),
        .clr_all      (clr_all),
        .stat         (stat)
    );

    mip_cause_enc #(.NOBJ(NOBJ)) u_enc (
        .pend     (pend),
        .stat_any (stat_any),
        .cause    (cause)
    );

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: r_d.ctrl = ctrl_t'(bus_wdata[2:0]);
                A_IELO: r_d.ie[HALF-1:0] = bus_wdata[HALF-1:0];
                A_IEHI: r_d.ie[NOBJ-1:HALF] = bus_wdata[HALF-1:0];
                default: ;
            endcase
        end
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  r_d.rdata = DW'(r_q.ctrl);
                A_STAT:  r_d.rdata = DW'(stat);
                A_CAUSE: r_d.rdata = cause;
                A_PLO:   r_d.rdata = DW'(pend[HALF-1:0]);
                A_PHI:   r_d.rdata = DW'(pend[NOBJ-1:HALF]);
                A_IELO:  r_d.rdata = DW'(r_q.ie[HALF-1:0]);
                A_IEHI:  r_d.rdata = DW'(r_q.ie[NOBJ-1:HALF]);
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign irq_o     = r_q.ctrl.glob_en & (stat_any | (|pend));

    // R9
    irq_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> r_q.ctrl.glob_en);

    // R4
    stat_wins_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_any |-> (cause == STAT_CODE));

    // R3
    cause_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_any && cause != '0) |-> pend[IW'(cause - 1'b1)]);

    // R3
    cause_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_any && cause != '0) |->
            ((pend & ((NOBJ'(1) << IW'(cause - 1'b1)) - NOBJ'(1))) == '0));

    // R4
    idle_cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_any && pend == '0) |-> (cause == '0));
endmodule

// File: tb/msg_irq_prioritizer_bench.sv
module msg_irq_prioritizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] obj_evt = '0;
    logic        ev_xfer_done = 1'b0;
    logic        ev_bus_err = 1'b0;
    logic        ev_bus_off = 1'b0;
    logic        ev_err_limit = 1'b0;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    msg_irq_prioritizer u_msg_irq_prioritizer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .obj_evt(obj_evt), .ev_xfer_done(ev_xfer_done), .ev_bus_err(ev_bus_err),
        .ev_bus_off(ev_bus_off), .ev_err_limit(ev_err_limit), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic obj_pulse(input logic [31:0] m);
        @(negedge clk);
        obj_evt = m;
        @(negedge clk);
        obj_evt = '0;
    endtask

    task automatic ev_pulse(input logic x, input logic b, input logic o, input logic l);
        @(negedge clk);
        ev_xfer_done = x; ev_bus_err = b; ev_bus_off = o; ev_err_limit = l;
        @(negedge clk);
        ev_xfer_done = 0; ev_bus_err = 0; ev_bus_off = 0; ev_err_limit = 0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 irq", 32'(irq_o), 0);
        for (int a = 0; a < 8; a++) begin
            if (a != 5) begin
                reg_rd(3'(a), v);
                check("R1 reg", 32'(v), 0);
            end
        end
    endtask

    task automatic t_obj_enable();
        logic [15:0] v;
        reg_wr(3'd6, 16'h0001);
        reg_wr(3'd7, 16'h8000);
        obj_pulse(32'h8000_0003);
        reg_rd(3'd3, v); check("R2 pend lo", 32'(v), 32'h0001);
        reg_rd(3'd4, v); check("R2 pend hi", 32'(v), 32'h8000);
        check("R9 irq off without global", 32'(irq_o), 0);
    endtask

    task automatic t_global();
        reg_wr(3'd0, 16'h0001);
        check("R9 irq on with global", 32'(irq_o), 1);
    endtask

    task automatic t_priority();
        logic [15:0] v;
        reg_rd(3'd2, v); check("R3 cause obj1 over obj32", 32'(v), 1);
        reg_wr(3'd5, 16'd1);
        reg_rd(3'd2, v); check("R3 cause obj32", 32'(v), 32);
        reg_wr(3'd6, 16'hFFFF);
        reg_wr(3'd7, 16'hFFFF);
        obj_pulse(32'h0008_0040);
        reg_rd(3'd2, v); check("R3 cause obj7", 32'(v), 7);
        reg_wr(3'd5, 16'd7);
        reg_rd(3'd2, v); check("R3 cause obj20", 32'(v), 20);
        reg_wr(3'd5, 16'd20);
        reg_wr(3'd5, 16'd33);
        reg_wr(3'd5, 16'd0);
        reg_wr(3'd5, 16'h4000);
        reg_rd(3'd4, v); check("R8 bad clear ignored hi", 32'(v), 32'h8000);
        reg_rd(3'd3, v); check("R8 bad clear ignored lo", 32'(v), 0);
        reg_wr(3'd5, 16'd32);
        reg_rd(3'd2, v); check("R4 cause idle", 32'(v), 0);
        check("R9 irq idle", 32'(irq_o), 0);
    endtask

    task automatic t_status();
        logic [15:0] v;
        ev_pulse(1, 0, 0, 0);
        check("R5 disabled no irq", 32'(irq_o), 0);
        reg_rd(3'd2, v); check("R5 disabled no cause", 32'(v), 0);
        reg_rd(3'd1, v); check("R7 flag latched", 32'(v), 32'h01);
        reg_wr(3'd0, 16'h0003);
        ev_pulse(0, 1, 0, 0);
        check("R5 irq", 32'(irq_o), 1);
        obj_pulse(32'h0000_0004);
        reg_rd(3'd2, v); check("R4 status over obj", 32'(v), 32'h8000);
        reg_rd(3'd1, v); check("R7 read value", 32'(v), 32'h12);
        reg_rd(3'd2, v); check("R7 cleared cause obj3", 32'(v), 3);
        reg_rd(3'd1, v); check("R7 cleared status", 32'(v), 0);
        reg_wr(3'd5, 16'd3);
    endtask

    task automatic t_error();
        logic [15:0] v;
        ev_pulse(0, 0, 1, 0);
        reg_rd(3'd2, v); check("R6 disabled no cause", 32'(v), 0);
        reg_rd(3'd1, v); check("R6 flag only", 32'(v), 32'h04);
        reg_wr(3'd0, 16'h0007);
        ev_pulse(0, 0, 0, 1);
        check("R6 irq", 32'(irq_o), 1);
        reg_rd(3'd2, v); check("R6 cause", 32'(v), 32'h8000);
        reg_rd(3'd1, v); check("R7 err read", 32'(v), 32'h28);
        reg_rd(3'd2, v); check("R7 err cleared", 32'(v), 0);
        check("R9 irq after read", 32'(irq_o), 0);
    endtask

    task automatic t_clear_code();
        logic [15:0] v;
        ev_pulse(1, 0, 0, 0);
        reg_wr(3'd5, 16'h8000);
        reg_rd(3'd2, v); check("R8 code clears cause", 32'(v), 0);
        reg_rd(3'd1, v); check("R8 code clears status", 32'(v), 0);
    endtask

    task automatic t_collision();
        logic [15:0] v;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 16'd5;
        obj_evt = 32'h0000_0010;
        @(negedge clk);
        bus_wr = 1'b0; obj_evt = '0;
        reg_rd(3'd3, v); check("R10 event beats clear", 32'(v), 32'h0010);
        reg_wr(3'd5, 16'd5);
        reg_rd(3'd3, v); check("R8 clear obj5", 32'(v), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_obj_enable();
        t_global();
        t_priority();
        t_status();
        t_error();
        t_clear_code();
        t_collision();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule